// File: doc/BRIEF.md
# Two-Argument Arctangent Special-Case Front End

This block sits ahead of a single-precision atan2 datapath. Each cycle it may accept a pair of IEEE 754 binary32 operands, y and x, marked by a valid strobe. It sorts each operand into one of four classes: NaN, infinity, zero or finite. It then decides whether the answer is already fixed without any arithmetic.

When the answer is fixed, the block returns the exact binary32 result with a special flag. That result is a quieted NaN, a signed zero, or a signed rounded multiple of pi. When it is not fixed, the block raises a core flag. The downstream unit then computes atan(|y/x|). It subtracts that value from pi when the negate flag shows that x is negative, and applies the returned sign of y.

The operands are resolved in a fixed order: NaN first, then an infinite x, then an infinite y, then the zero cases. Every result that is not a NaN takes the sign of y.

Top module: `arctan2_special_front`

## Requirements
- R1: While the synchronous reset is high, out_valid, out_special and out_core read 0 at the next clock, even if in_valid is high.
- R2: out_valid equals in_valid from exactly one clock earlier, so operands may stream on every cycle.
- R3: When out_valid is 1, exactly one of out_special and out_core is 1. When out_valid is 0, both are 0. out_result is all zeros unless out_special is 1. out_y_sign and out_x_neg are 0 unless out_core is 1.
- R4: If x is a NaN (exponent field bits 30:23 all ones, fraction field bits 22:0 nonzero), the result is x with fraction bit 22 forced to 1. This holds even when y is also a NaN.
- R5: If x is not a NaN and y is a NaN, the result is y with fraction bit 22 forced to 1.
- R6: If x is +infinity and y is not a NaN, the result is pi/4 (0x3F490FDB) when y is infinite and zero otherwise. The sign bit 31 is copied from y.
- R7: If x is -infinity and y is not a NaN, the result is 3pi/4 (0x4016CBE4) when y is infinite and pi (0x40490FDB) otherwise. The sign is copied from y.
- R8: If x is finite or zero and y is infinite, the result is pi/2 (0x3FC90FDB) with the sign of y.
- R9: If x is +0 or -0 and y is finite and nonzero, the result is pi/2 with the sign of y.
- R10: If y is +0 or -0 and no earlier case applies, the result is zero with the sign of y when x has sign bit 0, and pi with the sign of y when x has sign bit 1.
- R11: If both operands are finite and nonzero, out_core is 1, out_y_sign equals the sign bit of y, and out_x_neg equals the sign bit of x.
- R12: An operand with exponent field 0 and a nonzero fraction (a subnormal) is treated as finite and nonzero, never as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| in_y | input | 32 | binary32 numerator operand y |
| in_x | input | 32 | binary32 denominator operand x |
| out_valid | output | 1 | Registered result present |
| out_special | output | 1 | out_result holds the final answer |
| out_result | output | 32 | Resolved binary32 result, zero when not special |
| out_core | output | 1 | Operands need the arctangent datapath |
| out_y_sign | output | 1 | Sign for the core result to apply |
| out_x_neg | output | 1 | Core must subtract its magnitude from pi |

## Verification
The only state in the block is a single output register, so any internal fault reaches the ports one clock after the operands that cause it. A misordered priority shows up as the wrong constant, or as a core flag where a special flag was expected. A wrong sign source shows up as a flipped bit 31. A subnormal that is misread as zero turns a pi/2 or core answer into a zero or pi answer. The vectors pair each class of y with each class of x so that every one of these faults changes a visible bit. The bench also checks back-to-back operands and reset asserted mid-stream.

// File: rtl/arctan2_pkg.sv
package arctan2_pkg;
  localparam int FP_EXP_W = 8;
  localparam int FP_MAN_W = 23;
  localparam int FP_W     = 1 + FP_EXP_W + FP_MAN_W;

  typedef enum logic [1:0] {
    CLS_FINITE = 2'd0,
    CLS_ZERO   = 2'd1,
    CLS_INF    = 2'd2,
    CLS_NAN    = 2'd3
  } fp_cls_e;

  // Unsigned magnitudes; the sign bit is attached at resolution time.
  localparam logic [FP_W-2:0] MAG_ZERO = '0;
  localparam logic [FP_W-2:0] MAG_PI   = 31'h40490FDB;
  localparam logic [FP_W-2:0] MAG_PI2  = 31'h3FC90FDB;
  localparam logic [FP_W-2:0] MAG_PI4  = 31'h3F490FDB;
  localparam logic [FP_W-2:0] MAG_3PI4 = 31'h4016CBE4;

  typedef struct packed {
    logic            special;
    logic            core;
    logic [FP_W-1:0] result;
    logic            y_sign;
    logic            x_neg;
  } verdict_t;
endpackage

// File: rtl/fp_operand_class.sv
module fp_operand_class
  import arctan2_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] op,
  output fp_cls_e      cls
);
  logic exp_ones, exp_zero, man_nz;

  always_comb begin
    exp_ones = &op[W-2:MAN_W];
    exp_zero = ~|op[W-2:MAN_W];
    man_nz   = |op[MAN_W-1:0];
    // Subnormals (exp_zero with man_nz) fall through to finite.
    if (exp_ones)                 cls = man_nz ? CLS_NAN : CLS_INF;
    else if (exp_zero && !man_nz) cls = CLS_ZERO;
    else                          cls = CLS_FINITE;
  end
endmodule

// File: rtl/atan2_case_select.sv
module atan2_case_select
  import arctan2_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W    = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] y,
  input  logic [W-1:0] x,
  input  fp_cls_e      cls_y,
  input  fp_cls_e      cls_x,
  output verdict_t     verdict
);
  function automatic logic [W-1:0] quieten(input logic [W-1:0] v);
    return {v[W-1:MAN_W], 1'b1, v[MAN_W-2:0]};
  endfunction

  logic sy, sx;

  always_comb begin
    sy      = y[W-1];
    sx      = x[W-1];
    verdict = '0;
    verdict.special = 1'b1;
    if (cls_x == CLS_NAN) begin
      verdict.result = quieten(x);
    end else if (cls_y == CLS_NAN) begin
      verdict.result = quieten(y);
    end else if (cls_x == CLS_INF) begin
      if (sx) verdict.result = {sy, (cls_y == CLS_INF) ? MAG_3PI4 : MAG_PI};
      else    verdict.result = {sy, (cls_y == CLS_INF) ? MAG_PI4  : MAG_ZERO};
    end else if (cls_y == CLS_INF) begin
      verdict.result = {sy, MAG_PI2};
    end else if (cls_x == CLS_ZERO && cls_y != CLS_ZERO) begin
      verdict.result = {sy, MAG_PI2};
    end else if (cls_y == CLS_ZERO) begin
      verdict.result = {sy, sx ? MAG_PI : MAG_ZERO};
    end else begin
      verdict.special = 1'b0;
      verdict.core    = 1'b1;
      verdict.y_sign  = sy;
      verdict.x_neg   = sx;
    end
  end
endmodule

// File: rtl/arctan2_special_front.sv
module arctan2_special_front
  import arctan2_pkg::*;
#(
  parameter int EXP_W = FP_EXP_W,
  parameter int MAN_W = FP_MAN_W,
  localparam int W    = 1 + EXP_W + MAN_W,
  localparam int NOPS = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_y,
  input  logic [W-1:0] in_x,
  output logic         out_valid,
  output logic         out_special,
  output logic [W-1:0] out_result,
  output logic         out_core,
  output logic         out_y_sign,
  output logic         out_x_neg
);
  logic [W-1:0] operand [NOPS];
  fp_cls_e      cls     [NOPS];
  verdict_t     nxt;

  assign operand[0] = in_y;
  assign operand[1] = in_x;

  for (genvar g = 0; g < NOPS; g++) begin : g_cls
    fp_operand_class #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .op  (operand[g]),
      .cls (cls[g])
    );
  end

  atan2_case_select #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_sel (
    .y       (in_y),
    .x       (in_x),
    .cls_y   (cls[0]),
    .cls_x   (cls[1]),
    .verdict (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_special <= 1'b0;
      out_result  <= '0;
      out_core    <= 1'b0;
      out_y_sign  <= 1'b0;
      out_x_neg   <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_special <= in_valid & nxt.special;
      out_result  <= in_valid ? nxt.result : '0;
      out_core    <= in_valid & nxt.core;
      out_y_sign  <= in_valid & nxt.y_sign;
      out_x_neg   <= in_valid & nxt.x_neg;
    end
  end

  logic x_is_nan, res_is_nan;
  assign x_is_nan   = (&in_x[W-2:MAN_W]) && (|in_x[MAN_W-1:0]);
  assign res_is_nan = (&out_result[W-2:MAN_W]) && (|out_result[MAN_W-1:0]);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_special && !out_core));

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r3_one_route: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones({out_special, out_core}) == 1));

  a_r3_no_route_idle: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_special && !out_core));

  a_r4_x_nan_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && x_is_nan) |=> (out_special &&
      out_result == {$past(in_x[W-1:MAN_W]), 1'b1, $past(in_x[MAN_W-2:0])}));

  // Covers R6, R7, R8, R9 and R10: non-NaN special results carry the sign of y.
  a_r6_sign_of_y: assert property (@(posedge clk) disable iff (rst)
    (out_special && !res_is_nan) |-> (out_result[W-1] == $past(in_y[W-1])));

  a_r11_core_result_zero: assert property (@(posedge clk) disable iff (rst)
    out_core |-> (out_result == '0));
endmodule

// File: tb/sim_arctan2_special_front.sv
module sim_arctan2_special_front;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_y, in_x;
  logic        out_valid, out_special, out_core, out_y_sign, out_x_neg;
  logic [31:0] out_result;

  always #10 clk = ~clk;

  arctan2_special_front u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_y(in_y), .in_x(in_x),
    .out_valid(out_valid), .out_special(out_special), .out_result(out_result),
    .out_core(out_core), .out_y_sign(out_y_sign), .out_x_neg(out_x_neg)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam int NV = 26;
  // Tags: R4 0-1, R5 2-3, R6 4-7, R7 8-11, R8 12-13, R9 14-15, R10 16-19, R12 20-22, R11 23-25
  localparam int VQ [NV] = '{4,4,5,5,6,6,6,6,7,7,7,7,8,8,9,9,10,10,10,10,12,12,12,11,11,11};
  localparam logic [31:0] VY [NV] = '{
    32'h3F800000, 32'h7F800005, 32'hFF800010, 32'h7FC12345,
    32'hFF800000, 32'h7F800000, 32'hC0000000, 32'h00000000,
    32'h7F800000, 32'hFF800000, 32'h3F800000, 32'h80000000,
    32'hFF800000, 32'h7F800000, 32'hBF800000, 32'h40000000,
    32'h80000000, 32'h00000000, 32'h80000000, 32'h80000000,
    32'h00000001, 32'h00000000, 32'h00000001,
    32'h3F800000, 32'hBF800000, 32'hC2000000};
  localparam logic [31:0] VX [NV] = '{
    32'h7FC00001, 32'hFF800003, 32'h3F800000, 32'h7F800000,
    32'h7F800000, 32'h7F800000, 32'h7F800000, 32'h7F800000,
    32'hFF800000, 32'hFF800000, 32'hFF800000, 32'hFF800000,
    32'h3F800000, 32'h80000000, 32'h00000000, 32'h80000000,
    32'h3F800000, 32'hC0000000, 32'h00000000, 32'h80000000,
    32'h00000000, 32'h807FFFFF, 32'h80000001,
    32'h40000000, 32'hC0000000, 32'h3F000000};
  localparam logic [31:0] VR [NV] = '{
    32'h7FC00001, 32'hFFC00003, 32'hFFC00010, 32'h7FC12345,
    32'hBF490FDB, 32'h3F490FDB, 32'h80000000, 32'h00000000,
    32'h4016CBE4, 32'hC016CBE4, 32'h40490FDB, 32'hC0490FDB,
    32'hBFC90FDB, 32'h3FC90FDB, 32'hBFC90FDB, 32'h3FC90FDB,
    32'h80000000, 32'h40490FDB, 32'h80000000, 32'hC0490FDB,
    32'h3FC90FDB, 32'h40490FDB, 32'h00000000,
    32'h00000000, 32'h00000000, 32'h00000000};
  localparam bit VS [NV] = '{1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,1,0,0,0,0};

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b1; in_y = 32'h3F800000; in_x = 32'h7FC00000;
    repeat (2) @(posedge clk);
    #1;
    check("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    check("R1 special in reset", {31'd0, out_special}, 32'd0);
    check("R1 core in reset", {31'd0, out_core}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VQ[i], i);
      @(negedge clk);
      in_valid = 1'b1; in_y = VY[i]; in_x = VX[i];
      @(posedge clk);
      #1;
      check({tag, " R2 valid"}, {31'd0, out_valid}, 32'd1);
      check({tag, " R3 special"}, {31'd0, out_special}, {31'd0, VS[i]});
      check({tag, " R3 core"}, {31'd0, out_core}, {31'd0, !VS[i]});
      check({tag, " result"}, out_result, VR[i]);
      check({tag, " y_sign"}, {31'd0, out_y_sign}, {31'd0, VS[i] ? 1'b0 : VY[i][31]});
      check({tag, " x_neg"}, {31'd0, out_x_neg}, {31'd0, VS[i] ? 1'b0 : VX[i][31]});
    end

    // R2 and R3: an idle cycle drops every flag
    @(negedge clk);
    in_valid = 1'b0; in_y = 32'h3F800000; in_x = 32'h3F800000;
    @(posedge clk);
    #1;
    check("R2 idle valid", {31'd0, out_valid}, 32'd0);
    check("R3 idle special", {31'd0, out_special}, 32'd0);
    check("R3 idle core", {31'd0, out_core}, 32'd0);
    check("R3 idle result", out_result, 32'd0);

    // R1: reset asserted mid-stream with valid operands
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_y = 32'h7F800000; in_x = 32'hFF800000;
    @(posedge clk);
    #1;
    check("R1 mid reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 mid reset special", {31'd0, out_special}, 32'd0);

    // R11 after reset release, core operands on the first valid cycle
    @(negedge clk);
    rst = 1'b0; in_y = 32'hBF800000; in_x = 32'h40400000;
    @(posedge clk);
    #1;
    check("R11 post reset core", {31'd0, out_core}, 32'd1);
    check("R11 post reset y_sign", {31'd0, out_y_sign}, 32'd1);
    check("R11 post reset x_neg", {31'd0, out_x_neg}, 32'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule